// File: doc/BRIEF.md
# Set/Clear Peripheral Register Bank

A 32-bit register slave on an APB-style bus. It gives a peripheral core the usual set of control registers, and none of them needs a read-modify-write. Command bits are write-only and come out as single-cycle pulses. The mode register is a plain read/write word. The channel enable vector and the interrupt mask each have a write-one-to-set address, a write-one-to-clear address and a read-only view.

The peripheral core raises per-bit event inputs. Each event sets a sticky flag, and a read of the flag register clears the flags. The flags are ANDed with the interrupt mask and ORed into one interrupt request. Address decode uses word addresses only, and unmapped space reads as zero.

Register map (byte offsets; bits 1:0 of the address are ignored):

| Offset | Name | Access | Function |
|---|---|---|---|
| 0x00 | cmd | write-only | each 1 bit gives a one-cycle pulse on `cmd_o` |
| 0x04 | mode | read/write | drives `mode_o` |
| 0x08 | ch_set | write-only | 1 bits set bits of the enable vector |
| 0x0C | ch_clr | write-only | 1 bits clear bits of the enable vector |
| 0x10 | ch_stat | read-only | enable vector |
| 0x14 | irq_on | write-only | 1 bits set bits of the mask |
| 0x18 | irq_off | write-only | 1 bits clear bits of the mask |
| 0x1C | irq_mask | read-only | interrupt mask |
| 0x20 | evt_flags | read-only | sticky event flags, cleared by a read |

Top module: `setclr_reg_bank`

## Requirements
- R1: Only word accesses exist. Address bits 1:0 are ignored, so any address 0x04 to 0x07 selects the mode register.
- R2: A write of a 1 bit to cmd (0x00) drives that bit of `cmd_o` high for exactly one cycle, the cycle after the access-phase edge. 0 bits give no pulse, and cmd reads as 0.
- R3: The mode register (0x04) resets to 0 and reads back what was written. Bits at and above MODE_W (8) read 0 and ignore writes. `mode_o` follows the register.
- R4: A 1 written to ch_set (0x08) sets that enable bit, and a 1 written to ch_clr (0x0C) clears it. 0 bits leave the bit unchanged. ch_stat (0x10) and `chan_en_o` show the vector, and writes to ch_stat have no effect.
- R5: A 1 written to irq_on (0x14) sets that mask bit, and a 1 written to irq_off (0x18) clears it. irq_mask (0x1C) reads the mask.
- R6: `irq_o` is the OR over all bits of (event flags AND mask). It updates the cycle after a flag or the mask changes.
- R7: A high bit on `evt_i` at a clock edge sets that event flag. A read of evt_flags (0x20) returns the flags and then clears them. The enable vector is not affected.
- R8: If an event arrives in the same cycle as the clearing read, the event wins and its flag stays set.
- R9: Unmapped offsets (0x24 and up) read 0, and writes to them change nothing. `pready_o` is always 1.
- R10: After reset, every register reads 0 and all outputs are 0 except `pready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| psel_i | input | 1 | bus select |
| penable_i | input | 1 | access phase |
| pwrite_i | input | 1 | 1 = write |
| paddr_i | input | ADDR_W (8) | byte address |
| pwdata_i | input | 32 | write data |
| prdata_o | output | 32 | read data, valid in the access phase |
| pready_o | output | 1 | constant 1 |
| evt_i | input | EVT_W (8) | event inputs from the peripheral core |
| cmd_o | output | CMD_W (8) | one-cycle command pulses |
| mode_o | output | MODE_W (8) | mode value |
| chan_en_o | output | CH_W (8) | channel enable vector |
| irq_o | output | 1 | interrupt request |

## Verification
Read data is combinational, so it is due during the access phase itself. The bench compares it just after the falling edge inside that phase, before the clearing edge can change the flags. Command pulses, register updates and `irq_o` are due one cycle after the rising edge that completes the access or samples `evt_i`. Those checks are therefore made at the falling edge that follows that rising edge, and for `cmd_o` again one cycle later to confirm the pulse has ended. For the event-wins case, the event is applied in the same access-phase cycle as the flag read. The check confirms that the read returns the old flags and that a second read still shows the new one.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 9;

  typedef enum logic [3:0] {
    REG_CMD      = 4'd0,
    REG_MODE     = 4'd1,
    REG_CH_SET   = 4'd2,
    REG_CH_CLR   = 4'd3,
    REG_CH_STAT  = 4'd4,
    REG_IRQ_ON   = 4'd5,
    REG_IRQ_OFF  = 4'd6,
    REG_IRQ_MASK = 4'd7,
    REG_EVT      = 4'd8
  } reg_idx_e;
endpackage

// File: rtl/setclr_apb_dec.sv
module setclr_apb_dec
  import setclr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  output logic [NUM_REGS-1:0] wr_sel_o,
  output logic [NUM_REGS-1:0] rd_sel_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    word_idx;
  logic [NUM_REGS-1:0] hit;
  logic                access;
  logic                unused_lo;

  // word addressing: byte lanes ignored
  assign word_idx  = paddr_i[ADDR_W-1:2];
  assign unused_lo = ^paddr_i[1:0];
  assign access    = psel_i & penable_i;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
    assign hit[r] = (word_idx == IDX_W'(r));
  end

  assign wr_sel_o = hit & {NUM_REGS{access &  pwrite_i}};
  assign rd_sel_o = hit & {NUM_REGS{access & ~pwrite_i}};

  assert_dec_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o | rd_sel_o));
  assert_dec_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i) |-> ((wr_sel_o | rd_sel_o) == '0));
endmodule

// File: rtl/setclr_bank.sv
module setclr_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | wd_i;
    else if (clr_i) q_o <= q_o & ~wd_i;
  end

  // serves both the channel enables (R4) and the interrupt mask (R5)
  assert_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(wd_i)) == $past(wd_i)));
  assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(wd_i)) == '0));
  assert_zero_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) |=> ((q_o & ~$past(wd_i)) == ($past(q_o) & ~$past(wd_i))));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/setclr_evt_flags.sv
module setclr_evt_flags #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] q_o
);
  // hardware set overrides the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (rd_clr_i ? '0 : q_o) | evt_i;
  end

  assert_hw_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i |=> ((q_o & $past(evt_i)) == $past(evt_i)));
  assert_rd_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && evt_i == '0) |=> (q_o == '0));
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));
endmodule

// File: rtl/setclr_reg_bank.sv
module setclr_reg_bank
  import setclr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 8,
  parameter int MODE_W = 8,
  parameter int CH_W   = 8,
  parameter int EVT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CH_W-1:0]   chan_en_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] wr_sel, rd_sel;
  logic [MODE_W-1:0]   mode_q;
  logic [CMD_W-1:0]    cmd_q;
  logic [EVT_W-1:0]    mask_q, flags_q;
  logic                unused_wd;

  assign unused_wd = ^pwdata_i;
  assign pready_o  = 1'b1;

  setclr_apb_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i,
    .wr_sel_o(wr_sel), .rd_sel_o(rd_sel)
  );

  setclr_bank #(.W(CH_W)) u_chan (
    .clk_i, .rst_ni,
    .set_i(wr_sel[REG_CH_SET]), .clr_i(wr_sel[REG_CH_CLR]),
    .wd_i(pwdata_i[CH_W-1:0]), .q_o(chan_en_o)
  );

  setclr_bank #(.W(EVT_W)) u_mask (
    .clk_i, .rst_ni,
    .set_i(wr_sel[REG_IRQ_ON]), .clr_i(wr_sel[REG_IRQ_OFF]),
    .wd_i(pwdata_i[EVT_W-1:0]), .q_o(mask_q)
  );

  setclr_evt_flags #(.W(EVT_W)) u_flags (
    .clk_i, .rst_ni, .evt_i, .rd_clr_i(rd_sel[REG_EVT]), .q_o(flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (wr_sel[REG_MODE]) mode_q <= pwdata_i[MODE_W-1:0];
      // self-clearing: only the access cycle loads a nonzero value
      cmd_q <= wr_sel[REG_CMD] ? pwdata_i[CMD_W-1:0] : '0;
    end
  end

  always_comb begin
    prdata_o = '0;
    if (rd_sel[REG_MODE])     prdata_o[MODE_W-1:0] = mode_q;
    if (rd_sel[REG_CH_STAT])  prdata_o[CH_W-1:0]   = chan_en_o;
    if (rd_sel[REG_IRQ_MASK]) prdata_o[EVT_W-1:0]  = mask_q;
    if (rd_sel[REG_EVT])      prdata_o[EVT_W-1:0]  = flags_q;
  end

  assign cmd_o  = cmd_q;
  assign mode_o = mode_q;
  assign irq_o  = |(flags_q & mask_q);

  assert_cmd_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pwrite_i && paddr_i[ADDR_W-1:2] == '0)
      |=> (cmd_o == $past(pwdata_i[CMD_W-1:0])));
  assert_cmd_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=> (cmd_o == '0));
  assert_mode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=> $stable(mode_o));
  assert_chan_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel[REG_EVT] |=> $stable(chan_en_o));
endmodule

// File: tb/tb_setclr_reg_bank.sv
`timescale 1ns/1ps
module tb_setclr_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  evt = '0;
  logic [7:0]  cmd, mode, chan_en;
  logic        irq;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  setclr_reg_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .evt_i(evt), .cmd_o(cmd), .mode_o(mode),
    .chan_en_o(chan_en), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic apb_rd(input logic [7:0] a, input logic [31:0] e, input string tag,
                        input logic [7:0] ev = 8'h00);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); penable = 1; evt = ev;
    @(negedge clk); psel = 0; penable = 0; evt = '0;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  // monitor: read data is valid within the access phase
  always @(negedge clk) begin
    #1;
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) check(prdata, 32'hx, "monitor unexpected read");
      else check(prdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({24'h0, cmd}, 0, "R10 cmd_o reset");
    check({24'h0, mode}, 0, "R10 mode_o reset");
    check({24'h0, chan_en}, 0, "R10 chan_en_o reset");
    check({31'h0, irq}, 0, "R10 irq_o reset");
    for (int a = 0; a <= 8'h20; a += 4) apb_rd(8'(a), 0, "R10 register reset");

    apb_wr(8'h04, 32'hFFFF_FFFF);
    check({24'h0, mode}, 32'hFF, "R3 mode_o after write");
    apb_rd(8'h04, 32'h0000_00FF, "R3 mode upper bits read 0");
    apb_wr(8'h06, 32'h0000_005A);
    check({24'h0, mode}, 32'h5A, "R1 mode via offset 0x06");
    apb_rd(8'h07, 32'h5A, "R1 mode read at 0x07");

    apb_wr(8'h00, 32'h0000_0081);
    check({24'h0, cmd}, 32'h81, "R2 cmd pulse present");
    @(negedge clk);
    check({24'h0, cmd}, 0, "R2 cmd pulse ended");
    apb_wr(8'h00, 32'h0);
    check({24'h0, cmd}, 0, "R2 zero write no pulse");
    apb_rd(8'h00, 0, "R2 cmd reads 0");

    apb_wr(8'h08, 32'h0F);
    apb_wr(8'h0C, 32'h05);
    check({24'h0, chan_en}, 32'h0A, "R4 set then clear");
    apb_wr(8'h08, 32'h00);
    apb_wr(8'h10, 32'hFF);
    apb_rd(8'h10, 32'h0A, "R4 zero bits and status write ignored");

    apb_wr(8'h14, 32'h03);
    apb_wr(8'h18, 32'h01);
    apb_rd(8'h1C, 32'h02, "R5 mask on/off");

    pulse_evt(8'h01);
    check({31'h0, irq}, 0, "R6 masked flag no irq");
    pulse_evt(8'h02);
    check({31'h0, irq}, 1, "R6 unmasked flag irq");
    apb_rd(8'h20, 32'h03, "R7 flags read");
    check({31'h0, irq}, 0, "R7 irq after clearing read");
    apb_rd(8'h20, 32'h00, "R7 flags cleared");
    check({24'h0, chan_en}, 32'h0A, "R7 enables kept");

    pulse_evt(8'h04);
    check({31'h0, irq}, 0, "R6 flag before mask");
    apb_wr(8'h14, 32'h04);
    check({31'h0, irq}, 1, "R6 irq on mask set");
    apb_wr(8'h18, 32'h04);
    check({31'h0, irq}, 0, "R6 irq on mask clear");

    apb_rd(8'h20, 32'h04, "R8 read with coincident event", 8'h10);
    apb_rd(8'h20, 32'h10, "R8 event survives clear");

    apb_wr(8'h40, 32'hFFFF_FFFF);
    apb_wr(8'hFC, 32'hFFFF_FFFF);
    apb_rd(8'h40, 0, "R9 unmapped read");
    apb_rd(8'hFC, 0, "R9 unmapped read top");
    apb_rd(8'h04, 32'h5A, "R9 mode untouched");
    apb_rd(8'h10, 32'h0A, "R9 enables untouched");
    apb_rd(8'h1C, 32'h02, "R9 mask untouched");
    check({31'h0, pready}, 1, "R9 pready");

    repeat (3) @(negedge clk);
    check(exp_q.size(), 0, "scoreboard drained");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule